// File: doc/BRIEF.md
# USB Host-to-Device Receive Buffer Manager

This block sits between a USB full-speed protocol engine and a shared packet memory. It handles the data stage of OUT and SETUP transactions. When the engine signals the start of a data packet, the block chooses the handshake from four inputs: the endpoint's stall bit, its receive-enable bit, whether a free buffer is waiting, and whether there is room to report a finished packet. If the packet is accepted, the block takes the buffer ID at the head of a small free-ID queue. It then writes the incoming bytes into that buffer of the packet memory.

Software keeps the free-ID queue topped up. It collects finished packets from a descriptor queue, and each descriptor names the buffer, the payload length, the endpoint and whether the transaction was a SETUP. A packet that arrives with a bad CRC leaves no descriptor and returns no handshake. The buffer ID it was using stays at the head of the free-ID queue, so the host's retry lands in the same buffer. An interrupt line stays high while any descriptor waits to be read.

Top module: `usb_rx_bufmgr`

## Requirements
- R1: After reset, `hs_valid`, `mem_we`, `rxq_valid`, `rx_irq` and `av_full` are all low.
- R2: An accepted packet writes its k-th byte (k counted from 0, including CRC bytes) to `mem_addr` = id*BUF_BYTES + k. The id is the free-ID queue head at packet start, and IDs are used in the order software pushed them.
- R3: Only bytes with k < BUF_BYTES are written. Trailing CRC bytes are stored when they fit, and no byte is written outside an accepted packet.
- R4: The descriptor length is the byte count minus the 2 CRC bytes. It is 0 when the packet carries two or fewer bytes, and it never exceeds BUF_BYTES.
- R5: The descriptor reports the buffer ID, the endpoint and `rxq_setup` = 1 for SETUP (0 for OUT), in arrival order.
- R6: A packet to an endpoint whose `rx_enable` bit is clear gets NAK. It writes nothing and queues no descriptor.
- R7: When the free-ID queue is empty, every packet that is not stalled gets NAK.
- R8: When the descriptor queue is full (RXQ_DEPTH entries), every packet that is not stalled gets NAK.
- R9: A packet to an endpoint whose `stall` bit is set gets STALL, whatever the enable bit and queue state. It writes nothing.
- R10: On a bad CRC, no handshake is issued and no descriptor is queued. The free-ID head is kept, so the next accepted packet reuses that buffer.
- R11: `rx_irq` is high exactly while the descriptor queue holds at least one entry.
- R12: The handshake appears on `hs_valid`/`hs_code` for one cycle, in the cycle after `pkt_end` is sampled. The codes are ACK = 1, NAK = 2 and STALL = 3.
- R13: The free-ID queue holds AV_DEPTH entries. `av_full` is high when it is full, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | NUM_EP | Per-endpoint receive enable |
| stall | input | NUM_EP | Per-endpoint stall |
| av_push | input | 1 | Software pushes a free buffer ID |
| av_push_id | input | ID_W | Free buffer ID being pushed |
| av_full | output | 1 | Free-ID queue is full |
| pkt_start | input | 1 | Data stage of an OUT/SETUP begins |
| pkt_ep | input | EP_W | Target endpoint, valid with pkt_start |
| pkt_setup | input | 1 | 1 = SETUP, 0 = OUT, valid with pkt_start |
| byte_valid | input | 1 | A packet byte is present |
| byte_data | input | 8 | Packet byte |
| pkt_end | input | 1 | End of packet |
| pkt_crc_ok | input | 1 | CRC status, valid with pkt_end |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | ADDR_W | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| rxq_pop | input | 1 | Software removes the head descriptor |
| rxq_valid | output | 1 | A descriptor is waiting |
| rxq_buf | output | ID_W | Descriptor buffer ID |
| rxq_len | output | LEN_W | Descriptor payload length |
| rxq_ep | output | EP_W | Descriptor endpoint |
| rxq_setup | output | 1 | Descriptor SETUP flag |
| rx_irq | output | 1 | Packet-received interrupt |

## Verification
The bench builds the block with four endpoints and a two-entry descriptor queue. Everything else stays at its default: 32 buffers of 64 bytes and a four-entry free-ID queue. The small descriptor queue makes the queue-full NAK path reachable in a couple of packets. The small endpoint count lets every endpoint and both transaction types appear across the sweep. Packet sizes are swept from 0 to 66 bytes, with all 32 buffer IDs cycled through. This reaches the zero-length case, the 64-byte boundary where CRC bytes stop being stored, and the length cap.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  localparam int CRC_BYTES = 2;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // Stall wins, then any reason to refuse, otherwise accept.
  function automatic hs_e pick_hs(input logic ep_stall, input logic ep_en,
                                  input logic av_empty, input logic rxq_full);
    if (ep_stall) return HS_STALL;
    if (!ep_en || av_empty || rxq_full) return HS_NAK;
    return HS_ACK;
  endfunction

endpackage

// File: rtl/usb_rx_fifo.sv
module usb_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] i);
    return (i == AW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_idx <= nxt(wr_idx);
      if (do_pop)  rd_idx <= nxt(rd_idx);
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_idx] <= wdata;
  end

endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
  import usb_rx_pkg::*;
#(
  parameter int NUM_EP    = 12,
  parameter int NUM_BUF   = 32,
  parameter int BUF_BYTES = 64,
  parameter int EP_W      = 4,
  parameter int ID_W      = 5,
  parameter int LEN_W     = 7,
  parameter int ADDR_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] rx_enable,
  input  logic [NUM_EP-1:0] stall,
  input  logic              pkt_start,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic              pkt_setup,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              pkt_end,
  input  logic              pkt_crc_ok,
  input  logic              av_empty,
  input  logic [ID_W-1:0]   av_head,
  input  logic              rxq_full,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              commit,
  output logic [ID_W-1:0]   d_buf,
  output logic [LEN_W-1:0]  d_len,
  output logic [EP_W-1:0]   d_ep,
  output logic              d_setup,
  output logic              taking,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);
  localparam int CNT_W = $clog2(BUF_BYTES + CRC_BYTES + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_TAKE, ST_DROP} st_e;

  st_e              st;
  logic [ID_W-1:0]  cur_id;
  logic [EP_W-1:0]  cur_ep;
  logic             cur_setup;
  logic [CNT_W-1:0] byte_cnt;
  hs_e              held_hs;
  hs_e              start_hs;
  logic             ep_ok;
  logic             ep_stall, ep_en;

  // Byte address inside the shared packet memory.
  function automatic logic [ADDR_W-1:0] buf_addr(input logic [ID_W-1:0] id,
                                                 input logic [CNT_W-1:0] off);
    return ADDR_W'(id) * ADDR_W'(BUF_BYTES) + ADDR_W'(off);
  endfunction

  // Payload length: bytes seen minus CRC, floored at 0 and capped at a buffer.
  function automatic logic [LEN_W-1:0] data_len(input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] p;
    if (n <= CNT_W'(CRC_BYTES)) return '0;
    p = n - CNT_W'(CRC_BYTES);
    if (p > CNT_W'(BUF_BYTES)) return LEN_W'(BUF_BYTES);
    return LEN_W'(p);
  endfunction

  assign ep_ok    = (32'(pkt_ep) < NUM_EP);
  assign ep_stall = ep_ok ? stall[pkt_ep] : 1'b0;
  assign ep_en    = ep_ok ? rx_enable[pkt_ep] : 1'b0;
  assign start_hs = pick_hs(ep_stall, ep_en, av_empty, rxq_full);

  assign taking    = (st == ST_TAKE);
  assign mem_we    = byte_valid && taking && (byte_cnt < CNT_W'(BUF_BYTES));
  assign mem_addr  = buf_addr(cur_id, byte_cnt);
  assign mem_wdata = byte_data;

  assign commit  = pkt_end && taking && pkt_crc_ok;
  assign d_buf   = cur_id;
  assign d_len   = data_len(byte_cnt);
  assign d_ep    = cur_ep;
  assign d_setup = cur_setup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_id    <= '0;
      cur_ep    <= '0;
      cur_setup <= 1'b0;
      byte_cnt  <= '0;
      held_hs   <= HS_NONE;
      hs_valid  <= 1'b0;
      hs_code   <= HS_NONE;
    end else begin
      hs_valid <= 1'b0;
      if (pkt_start) begin
        st        <= (start_hs == HS_ACK) ? ST_TAKE : ST_DROP;
        held_hs   <= start_hs;
        cur_id    <= av_head;
        cur_ep    <= pkt_ep;
        cur_setup <= pkt_setup;
        byte_cnt  <= '0;
      end else if (pkt_end) begin
        st       <= ST_IDLE;
        hs_valid <= (st != ST_IDLE) && pkt_crc_ok;
        hs_code  <= held_hs;
      end else if (byte_valid && st != ST_IDLE && byte_cnt != '1) begin
        byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/usb_rx_bufmgr.sv
module usb_rx_bufmgr #(
  parameter int NUM_EP    = 12,
  parameter int NUM_BUF   = 32,
  parameter int BUF_BYTES = 64,
  parameter int AV_DEPTH  = 4,
  parameter int RXQ_DEPTH = 4,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int ID_W   = $clog2(NUM_BUF),
  localparam int LEN_W  = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W = $clog2(NUM_BUF * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] rx_enable,
  input  logic [NUM_EP-1:0] stall,
  input  logic              av_push,
  input  logic [ID_W-1:0]   av_push_id,
  output logic              av_full,
  input  logic              pkt_start,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic              pkt_setup,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              pkt_end,
  input  logic              pkt_crc_ok,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              rxq_pop,
  output logic              rxq_valid,
  output logic [ID_W-1:0]   rxq_buf,
  output logic [LEN_W-1:0]  rxq_len,
  output logic [EP_W-1:0]   rxq_ep,
  output logic              rxq_setup,
  output logic              rx_irq
);
  localparam int DESC_W = ID_W + LEN_W + EP_W + 1;

  logic              av_empty;
  logic [ID_W-1:0]   av_head;
  logic              rxq_full, rxq_empty;
  logic              commit, taking;
  logic [ID_W-1:0]   d_buf;
  logic [LEN_W-1:0]  d_len;
  logic [EP_W-1:0]   d_ep;
  logic              d_setup;
  logic [DESC_W-1:0] desc_in, desc_out;

  usb_rx_fifo #(.W(ID_W), .DEPTH(AV_DEPTH)) u_avq (
    .clk(clk), .rst_n(rst_n),
    .push(av_push), .wdata(av_push_id),
    .pop(commit), .rdata(av_head),
    .empty(av_empty), .full(av_full)
  );

  usb_rx_ctrl #(
    .NUM_EP(NUM_EP), .NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES),
    .EP_W(EP_W), .ID_W(ID_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rx_enable(rx_enable), .stall(stall),
    .pkt_start(pkt_start), .pkt_ep(pkt_ep), .pkt_setup(pkt_setup),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
    .av_empty(av_empty), .av_head(av_head), .rxq_full(rxq_full),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .commit(commit),
    .d_buf(d_buf), .d_len(d_len), .d_ep(d_ep), .d_setup(d_setup),
    .taking(taking),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  assign desc_in = {d_buf, d_len, d_ep, d_setup};

  usb_rx_fifo #(.W(DESC_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(commit), .wdata(desc_in),
    .pop(rxq_pop), .rdata(desc_out),
    .empty(rxq_empty), .full(rxq_full)
  );

  assign {rxq_buf, rxq_len, rxq_ep, rxq_setup} = desc_out;
  assign rxq_valid = !rxq_empty;
  assign rx_irq    = !rxq_empty;

endmodule

// File: rtl/usb_rx_bufmgr_chk.sv
module usb_rx_bufmgr_chk (
  input logic clk,
  input logic rst_n,
  input logic commit,
  input logic av_empty,
  input logic rxq_full,
  input logic taking,
  input logic mem_we,
  input logic pkt_end,
  input logic pkt_crc_ok,
  input logic hs_valid,
  input logic rx_irq
);
  // R8
  no_rxq_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !rxq_full);

  // R7
  no_av_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !av_empty);

  // R10
  commit_needs_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> pkt_crc_ok);

  // R12
  hs_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(pkt_end) && $past(pkt_crc_ok));

  // R12
  hs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  // R11
  irq_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rx_irq);

  // R3
  write_only_taking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> taking);

endmodule

bind usb_rx_bufmgr usb_rx_bufmgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .av_empty(av_empty),
  .rxq_full(rxq_full), .taking(taking), .mem_we(mem_we),
  .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .hs_valid(hs_valid),
  .rx_irq(rx_irq)
);

// File: tb/test_usb_rx_bufmgr.sv
module test_usb_rx_bufmgr;
  localparam int NUM_EP = 4;
  localparam int NUM_BUF = 32;
  localparam int BUF_BYTES = 64;
  localparam int AV_DEPTH = 4;
  localparam int RXQ_DEPTH = 2;
  localparam int EP_W = 2;
  localparam int ID_W = 5;
  localparam int LEN_W = 7;
  localparam int ADDR_W = 11;

  logic clk = 0, rst_n = 0;
  logic [NUM_EP-1:0] en = '0, stl = '0;
  logic av_push = 0; logic [ID_W-1:0] av_push_id = '0;
  logic av_full;
  logic pkt_start = 0, pkt_setup = 0, byte_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
  logic [EP_W-1:0] pkt_ep = '0;
  logic [7:0] byte_data = '0;
  logic hs_valid; logic [1:0] hs_code;
  logic mem_we; logic [ADDR_W-1:0] mem_addr; logic [7:0] mem_wdata;
  logic rxq_pop = 0, rxq_valid, rxq_setup, rx_irq;
  logic [ID_W-1:0] rxq_buf; logic [LEN_W-1:0] rxq_len; logic [EP_W-1:0] rxq_ep;

  int checks = 0, errors = 0, cycles = 0;
  int av_m[$];
  int eq_buf[$], eq_len[$], eq_ep[$], eq_set[$];
  int rxq_n = 0;
  int next_id = 0;

  always #10 clk = ~clk;

  usb_rx_bufmgr #(.NUM_EP(NUM_EP), .NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES),
                  .AV_DEPTH(AV_DEPTH), .RXQ_DEPTH(RXQ_DEPTH)) i_usb_rx_bufmgr (
    .clk(clk), .rst_n(rst_n), .rx_enable(en), .stall(stl),
    .av_push(av_push), .av_push_id(av_push_id), .av_full(av_full),
    .pkt_start(pkt_start), .pkt_ep(pkt_ep), .pkt_setup(pkt_setup),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
    .hs_valid(hs_valid), .hs_code(hs_code),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rxq_pop(rxq_pop), .rxq_valid(rxq_valid), .rxq_buf(rxq_buf),
    .rxq_len(rxq_len), .rxq_ep(rxq_ep), .rxq_setup(rxq_setup), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_av(input int id);
    @(negedge clk);
    av_push = 1; av_push_id = ID_W'(id);
    @(negedge clk);
    av_push = 0;
    if (av_m.size() < AV_DEPTH) av_m.push_back(id);
  endtask

  // Send one packet of n bytes (payload plus CRC) and check writes and handshake.
  task automatic send(input int ep, input bit setup, input int n, input bit crc);
    int exp_hs, id, bad;
    bit take;
    if (stl[ep]) exp_hs = 3;
    else if (!en[ep] || av_m.size() == 0 || rxq_n == RXQ_DEPTH) exp_hs = 2;
    else exp_hs = 1;
    take = (exp_hs == 1);
    id = take ? av_m[0] : 0;
    bad = 0;
    @(negedge clk);
    pkt_start = 1; pkt_ep = EP_W'(ep); pkt_setup = setup;
    @(negedge clk);
    pkt_start = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = 8'((i * 13 + ep * 7) & 255);
      #1;
      if (mem_we !== (take && i < BUF_BYTES)) bad++;
      else if (mem_we && (mem_addr !== ADDR_W'(id * BUF_BYTES + i) ||
                          mem_wdata !== byte_data)) bad++;
      @(negedge clk);
    end
    byte_valid = 0; pkt_end = 1; pkt_crc_ok = crc;
    #1;
    if (mem_we !== 1'b0) bad++;
    @(negedge clk);
    pkt_end = 0; pkt_crc_ok = 0;
    // R2 R3: address, data and write window of every byte
    chk(bad == 0, "R2/R3 memory writes", bad, 0);
    // R12 R10: handshake one cycle after end, absent on bad CRC
    chk(hs_valid === crc, "R12/R10 hs_valid", hs_valid, crc);
    if (crc) chk(hs_code === 2'(exp_hs), "R12 hs_code (R6 R7 R8 R9)", hs_code, exp_hs);
    @(negedge clk);
    chk(hs_valid === 1'b0, "R12 hs one cycle", hs_valid, 0);
    if (take && crc) begin
      void'(av_m.pop_front());
      rxq_n++;
      eq_buf.push_back(id);
      eq_len.push_back(n <= 2 ? 0 : (n - 2 > BUF_BYTES ? BUF_BYTES : n - 2));
      eq_ep.push_back(ep);
      eq_set.push_back(setup);
    end
  endtask

  task automatic pop_check();
    int b, l, e, s;
    @(negedge clk);
    chk(rxq_valid === 1'b1, "R5 rxq_valid", rxq_valid, 1);
    b = eq_buf.pop_front(); l = eq_len.pop_front();
    e = eq_ep.pop_front(); s = eq_set.pop_front();
    chk(rxq_buf === ID_W'(b), "R2/R5 desc buffer", rxq_buf, b);
    chk(rxq_len === LEN_W'(l), "R4 desc length", rxq_len, l);
    chk(rxq_ep === EP_W'(e), "R5 desc endpoint", rxq_ep, e);
    chk(rxq_setup === s[0], "R5 desc setup flag", rxq_setup, s);
    rxq_pop = 1;
    @(negedge clk);
    rxq_pop = 0;
    rxq_n--;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(hs_valid === 0, "R1 hs_valid", hs_valid, 0);
    chk(mem_we === 0, "R1 mem_we", mem_we, 0);
    chk(rxq_valid === 0, "R1 rxq_valid", rxq_valid, 0);
    chk(rx_irq === 0, "R1 rx_irq", rx_irq, 0);
    chk(av_full === 0, "R1 av_full", av_full, 0);

    // R13: fill, then overfill
    push_av(3); push_av(17); push_av(31); push_av(0);
    chk(av_full === 1, "R13 av_full", av_full, 1);
    push_av(9);
    next_id = 1;

    // Sweep of sizes, endpoints and transaction types (R2 R3 R4 R5)
    en = '1;
    for (int n = 0; n <= 66; n++) begin
      if (av_m.size() < 2) begin
        push_av(next_id);
        next_id = (next_id + 1) % NUM_BUF;
      end
      send(n % NUM_EP, n[0], n, 1);
      // R11
      chk(rx_irq === 1, "R11 irq with entry", rx_irq, 1);
      pop_check();
      chk(rx_irq === 0, "R11 irq after drain", rx_irq, 0);
    end

    // R6: disabled endpoint
    en[2] = 0;
    send(2, 0, 10, 1);
    chk(rxq_valid === 0, "R6 no descriptor", rxq_valid, 0);
    send(2, 1, 3, 1);

    // R9: stall on enabled and disabled endpoints, any type
    stl[1] = 1; send(1, 0, 4, 1); send(1, 1, 4, 1);
    stl[2] = 1; send(2, 0, 4, 1);
    chk(rxq_valid === 0, "R9 no descriptor", rxq_valid, 0);
    stl = '0; en = '1;

    // R8: descriptor queue full
    while (av_m.size() < AV_DEPTH) begin
      push_av(next_id); next_id = (next_id + 1) % NUM_BUF;
    end
    send(0, 0, 6, 1); send(3, 1, 10, 1);
    send(1, 0, 8, 1);
    chk(rx_irq === 1, "R11 irq full queue", rx_irq, 1);
    pop_check();
    chk(rx_irq === 1, "R11 irq one left", rx_irq, 1);
    pop_check();
    chk(rx_irq === 0, "R11 irq empty", rx_irq, 0);

    // R7: free-ID queue empty
    while (av_m.size() > 0) begin
      send(0, 0, 5, 1);
      pop_check();
    end
    send(0, 0, 5, 1);
    send(3, 1, 2, 1);
    chk(rxq_valid === 0, "R7 no descriptor", rxq_valid, 0);

    // R10: bad CRC keeps the buffer for the retry
    push_av(22); push_av(7);
    send(1, 0, 12, 0);
    chk(rxq_valid === 0, "R10 no descriptor", rxq_valid, 0);
    send(1, 0, 12, 1);
    pop_check();
    send(2, 1, 66, 0);
    send(2, 1, 66, 1);
    pop_check();

    finish_run();
  end
endmodule